// File: doc/BRIEF.md
# Matrix Tile Four-Slice Readout

This block holds a square matrix tile store of (VL/8) × (VL/8) bytes and returns four consecutive slices of one tile as four vector-wide words. A request names an element size, a tile number, a direction (rows or columns), one of four 32-bit index registers, a small immediate offset and a destination group. The block picks the starting slice from the index value and the offset, takes the next three slices with wrap-around, gathers them from the store and gives each one a destination register number. The result appears one cycle after the request.

Tiles of one element size are interleaved in the store. Element row `r` of tile `t` sits in store byte row `r × tiles + t`, where `tiles` is 1, 2, 4 or 8 for 8, 16, 32 or 64-bit elements. A row slice is one store row. A column slice collects element `c` from every row of the tile, and the tile's row 0 goes into the least significant element. A plain byte-row write port loads the store. A request with a tile number or offset that is not allowed for its size sets an error flag and returns all-zero words and register numbers.

Top module: `mts_readout`

## Requirements
- R1: `resp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low after every cycle without a request. The response outputs change only on a request.
- R2: The element size code is 0, 1, 2 or 3 for 8, 16, 32 or 64 bits. With `req_vert`=0, output word k (`resp_vec[k*VL +: VL]`) equals store row `s_k × T + tile`, where T = 1 << size code.
- R3: With `req_vert`=1, output word k holds, at element position r, element `s_k` of store row `r × T + tile`, for every r from 0 to E−1, where E = (VL/8) >> size code.
- R4: s_0 = (index value + offset) mod E, and s_k = (s_0 + k) mod E, so the slice numbers wrap past E−1 to 0.
- R5: The index value is `idx_regs[sel*32 +: 32]`, where `sel` is `req_idx_sel`. Selects 0 to 3 stand for scalar registers 12 to 15.
- R6: The offset is allowed only if it is a multiple of 4 and at most 12 (8-bit), at most 4 (16-bit), or exactly 0 (32-bit and 64-bit). Any other offset sets `resp_err`.
- R7: The tile number must be below 1, 2, 4 or 8 for size codes 0 to 3. A higher tile number sets `resp_err`.
- R8: When `resp_err` is set, `resp_vec` and `resp_dst` are all zero.
- R9: For a legal request, `resp_dst[k*5 +: 5]` = `req_dst_grp` × 4 + k. Every word of all four outputs is driven, with no masking.
- R10: When `wr_en` is high, `wr_data` is written to store row `wr_row`. A request made in the same cycle still reads the row's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Store row write enable |
| wr_row | input | $clog2(VL/8) | Store row to write |
| wr_data | input | VL | Row data |
| req_valid | input | 1 | Read request strobe |
| req_esz | input | 2 | Element size code (0:8, 1:16, 2:32, 3:64 bits) |
| req_tile | input | 3 | Tile number |
| req_vert | input | 1 | 0 selects rows, 1 selects columns |
| req_idx_sel | input | 2 | Index register select (registers 12 to 15) |
| idx_regs | input | 128 | The four 32-bit index register values |
| req_off | input | 4 | Immediate slice offset |
| req_dst_grp | input | 3 | Destination group; the first register is this value × 4 |
| resp_valid | output | 1 | Response strobe |
| resp_err | output | 1 | Illegal tile or offset |
| resp_vec | output | 4*VL | Four slice words, slice k at bits k*VL |
| resp_dst | output | 20 | Four 5-bit destination register numbers |

## Verification
Every response, both data and error, is due exactly one clock edge after the edge that samples its request. Each item the driver queues records that edge number, and the monitor compares the item only on the falling edge that follows that edge. A response that arrives early, late or without a request is reported as an R1 failure. A write made in the same cycle as a request is applied to the bench's byte model only after the expected words for that request have been computed, so the old-data rule is checked at the one cycle where it matters.

// File: rtl/mts_pkg.sv
package mts_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  // elements of the chosen size in one vector of nbytes bytes
  function automatic int unsigned elems_per_vec(int unsigned nbytes, logic [1:0] esz);
    return nbytes >> esz;
  endfunction

  // number of tiles available at an element size
  function automatic int unsigned tiles_at(logic [1:0] esz);
    return 32'd1 << esz;
  endfunction

  function automatic logic tile_ok(logic [1:0] esz, logic [2:0] tile);
    return 32'(tile) < tiles_at(esz);
  endfunction

  // offset must be a multiple of four, capped by the 128-bit segment size
  function automatic logic offset_ok(logic [1:0] esz, logic [3:0] off);
    logic ok;
    if (off[1:0] != 2'b00) ok = 1'b0;
    else begin
      case (esz)
        ESZ_8:   ok = (off <= 4'd12);
        ESZ_16:  ok = (off <= 4'd4);
        default: ok = (off == 4'd0);
      endcase
    end
    return ok;
  endfunction

  // slice number k of a request; ne is a power of two
  function automatic logic [31:0] slice_num(logic [31:0] base, logic [3:0] off,
                                            int unsigned k, int unsigned ne);
    return (base + 32'(off) + 32'(k)) & (32'(ne) - 32'd1);
  endfunction

endpackage

// File: rtl/mts_store.sv
module mts_store #(
  parameter int VL = 256,
  localparam int NB = VL / 8,
  localparam int RW = $clog2(NB)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [RW-1:0]          wr_row,
  input  logic [VL-1:0]          wr_data,
  output logic [NB-1:0][VL-1:0]  rows_o
);

  logic [NB-1:0][VL-1:0] mem;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
  end

  assign rows_o = mem;

  // R10: a written row shows the written data one edge later
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rows_o[$past(wr_row)] == $past(wr_data));

endmodule

// File: rtl/mts_slice_gather.sv
module mts_slice_gather #(
  parameter int VL = 256,
  localparam int NB = VL / 8,
  localparam int RW = $clog2(NB)
) (
  input  logic [NB-1:0][VL-1:0] rows_i,
  input  logic [1:0]            esz_i,
  input  logic [2:0]            tile_i,
  input  logic                  vert_i,
  input  logic [RW-1:0]         slice_i,
  output logic [VL-1:0]         word_o
);

  logic [3:0][VL-1:0] cand;

  for (genvar e = 0; e < 4; e++) begin : g_size
    localparam int EB = 1 << e;     // bytes per element
    localparam int NE = NB / EB;    // elements per vector
    localparam int NT = 1 << e;     // interleaved tiles
    localparam int EW = EB * 8;     // element width in bits

    logic [RW-1:0] col;
    logic [VL-1:0] hword;
    logic [VL-1:0] vword;

    always_comb begin
      col   = slice_i & RW'(NE - 1);
      hword = rows_i[RW'(int'(col) * NT + int'(tile_i))];
      for (int r = 0; r < NE; r++) begin
        vword[r*EW +: EW] = rows_i[RW'(r * NT + int'(tile_i))][int'(col)*EW +: EW];
      end
    end

    assign cand[e] = vert_i ? vword : hword;
  end

  assign word_o = cand[esz_i];

endmodule

// File: rtl/mts_readout.sv
module mts_readout #(
  parameter int VL = 256,
  localparam int NB = VL / 8,
  localparam int RW = $clog2(NB),
  localparam int NS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_row,
  input  logic [VL-1:0]     wr_data,
  input  logic              req_valid,
  input  logic [1:0]        req_esz,
  input  logic [2:0]        req_tile,
  input  logic              req_vert,
  input  logic [1:0]        req_idx_sel,
  input  logic [127:0]      idx_regs,
  input  logic [3:0]        req_off,
  input  logic [2:0]        req_dst_grp,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [NS*VL-1:0]  resp_vec,
  output logic [NS*5-1:0]   resp_dst
);
  import mts_pkg::*;

  logic [NB-1:0][VL-1:0] rows;
  logic [31:0]           base_val;
  logic [RW-1:0]         slice_w [NS];
  logic [NS*VL-1:0]      gathered;
  logic [NS*5-1:0]       dst_w;
  logic                  bad_tile;
  logic                  bad_off;
  logic                  req_bad;

  mts_store #(.VL(VL)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_data (wr_data),
    .rows_o  (rows)
  );

  assign base_val = idx_regs[req_idx_sel*32 +: 32];
  assign bad_tile = !tile_ok(req_esz, req_tile);
  assign bad_off  = !offset_ok(req_esz, req_off);
  assign req_bad  = bad_tile || bad_off;

  for (genvar k = 0; k < NS; k++) begin : g_slice
    assign slice_w[k] = RW'(slice_num(base_val, req_off, k,
                                      elems_per_vec(NB, req_esz)));
    assign dst_w[k*5 +: 5] = {req_dst_grp, 2'(k)};

    mts_slice_gather #(.VL(VL)) u_gather (
      .rows_i  (rows),
      .esz_i   (req_esz),
      .tile_i  (req_tile),
      .vert_i  (req_vert),
      .slice_i (slice_w[k]),
      .word_o  (gathered[k*VL +: VL])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_vec   <= '0;
      resp_dst   <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_err <= req_bad;
        resp_vec <= req_bad ? '0 : gathered;
        resp_dst <= req_bad ? '0 : dst_w;
      end
    end
  end

  // R1: one response per request, one cycle later
  assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  assert_no_stray_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && $stable(resp_vec) && $stable(resp_dst));

  // R7: a tile number beyond the size's tile count is flagged
  assert_bad_tile_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (32'(req_tile) >= (32'd1 << req_esz))) |=> resp_err);

  // R8: error responses carry no data
  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_err) |-> (resp_vec == '0 && resp_dst == '0));

  // R9: destinations are one aligned group of four consecutive registers
  assert_dst_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_err) |->
      (resp_dst[1:0] == 2'd0 && resp_dst[9:5] == resp_dst[4:0] + 5'd1 &&
       resp_dst[14:10] == resp_dst[4:0] + 5'd2 &&
       resp_dst[19:15] == resp_dst[4:0] + 5'd3));

endmodule

// File: tb/mts_readout_test.sv
module mts_readout_test;
  localparam int VL = 256;
  localparam int NB = VL / 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_row = '0;
  logic [VL-1:0] wr_data = '0;
  logic req_valid = 1'b0;
  logic [1:0] req_esz = '0;
  logic [2:0] req_tile = '0;
  logic req_vert = 1'b0;
  logic [1:0] req_idx_sel = '0;
  logic [3:0] req_off = '0;
  logic [2:0] req_dst_grp = '0;
  logic [31:0] regs [4];
  logic [127:0] idx_regs;
  logic resp_valid, resp_err;
  logic [4*VL-1:0] resp_vec;
  logic [19:0] resp_dst;

  assign idx_regs = {regs[3], regs[2], regs[1], regs[0]};

  mts_readout #(.VL(VL)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .req_valid(req_valid), .req_esz(req_esz), .req_tile(req_tile),
    .req_vert(req_vert), .req_idx_sel(req_idx_sel), .idx_regs(idx_regs),
    .req_off(req_off), .req_dst_grp(req_dst_grp), .resp_valid(resp_valid),
    .resp_err(resp_err), .resp_vec(resp_vec), .resp_dst(resp_dst));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [4*VL-1:0] vec;
    logic [19:0]     dst;
    logic            err;
    int              due;
    string           tag;
  } exp_t;

  exp_t sbq[$];
  logic [7:0] model [NB][NB];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // byte-level model of one slice word
  function automatic logic [VL-1:0] model_word(int esz, int t, bit v, int s);
    logic [VL-1:0] w;
    int eb, ne, nt;
    eb = 1 << esz; ne = NB / eb; nt = 1 << esz;
    w = '0;
    for (int e = 0; e < ne; e++)
      for (int b = 0; b < eb; b++)
        w[(e*eb+b)*8 +: 8] = v ? model[e*nt+t][s*eb+b] : model[s*nt+t][e*eb+b];
    return w;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [4*VL-1:0] act, logic [4*VL-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic wr_idle();
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic write_row(int r);
    logic [VL-1:0] d;
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < NB; b++) begin
      d[b*8 +: 8] = 8'((r*53) ^ (b*151) ^ (r + 3*b + 7));
      model[r][b] = d[b*8 +: 8];
    end
    wr_en = 1'b1; wr_row = 5'(r); wr_data = d;
  endtask

  // drive one request, optionally with a write in the same cycle
  task automatic send(int esz, int t, bit v, int sel, int off, int grp, string tag,
                      bit do_wr = 1'b0, int wrow = 0);
    exp_t it;
    int ne, nt, first, cap;
    bit legal;
    logic [VL-1:0] d;
    @(negedge clk);
    req_valid = 1'b1; req_esz = 2'(esz); req_tile = 3'(t); req_vert = v;
    req_idx_sel = 2'(sel); req_off = 4'(off); req_dst_grp = 3'(grp);
    ne = NB >> esz; nt = 1 << esz;
    cap = (esz == 0) ? 12 : (esz == 1) ? 4 : 0;
    legal = (off % 4 == 0) && (off <= cap) && (t < nt);
    it.vec = '0; it.dst = '0; it.err = !legal; it.tag = tag; it.due = cyc + 1;
    if (legal) begin
      first = (int'(regs[sel] % 32'(ne)) + off) % ne;
      for (int k = 0; k < 4; k++) begin
        it.vec[k*VL +: VL] = model_word(esz, t, v, (first + k) % ne);
        it.dst[k*5 +: 5] = 5'(grp*4 + k);
      end
    end
    sbq.push_back(it);
    if (do_wr) begin
      for (int b = 0; b < NB; b++) begin
        d[b*8 +: 8] = 8'(255 - b - wrow);
        model[wrow][b] = d[b*8 +: 8];
      end
      wr_en = 1'b1; wr_row = 5'(wrow); wr_data = d;
    end else wr_en = 1'b0;
  endtask

  // monitor: compare each response on its due cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (sbq.size() > 0 && sbq[0].due == cyc) begin
          exp_t it;
          it = sbq.pop_front();
          check(resp_valid == 1'b1, "R1", "resp_valid on due cycle", 4096'(resp_valid), 4096'(1));
          check(resp_err == it.err, it.tag, "resp_err", 4096'(resp_err), 4096'(it.err));
          check(resp_vec == it.vec, it.tag, "resp_vec", resp_vec, it.vec);
          check(resp_dst == it.dst, (it.tag == "R9") ? "R9" : it.tag, "resp_dst", 4096'(resp_dst), 4096'(it.dst));
        end else if (resp_valid) begin
          check(1'b0, "R1", "unexpected resp_valid", 4096'(1), 4096'(0));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    regs[0] = 32'd7; regs[1] = 32'd30; regs[2] = 32'hFFFF_FFFE; regs[3] = 32'd65;
    repeat (3) @(negedge clk);
    check(resp_valid == 1'b0, "R1", "reset resp_valid", 4096'(resp_valid), 4096'(0));
    check(resp_err == 1'b0, "R8", "reset resp_err", 4096'(resp_err), 4096'(0));
    check(resp_vec == '0, "R8", "reset resp_vec", resp_vec, '0);
    rst_n = 1'b1;
    for (int r = 0; r < NB; r++) write_row(r);
    wr_idle();
    // R2 row slices at each size
    send(0, 0, 0, 0, 0, 1, "R2");
    send(1, 1, 0, 3, 4, 2, "R2");
    send(2, 3, 0, 0, 0, 3, "R2");
    send(3, 7, 0, 1, 0, 4, "R2");
    wr_idle();
    // R3 column slices at each size
    send(0, 0, 1, 0, 8, 0, "R3");
    send(1, 0, 1, 1, 0, 5, "R3");
    send(2, 2, 1, 3, 0, 6, "R3");
    send(3, 5, 1, 0, 0, 1, "R3");
    wr_idle(); wr_idle();
    // R4 wrap-around of slice numbers
    send(0, 0, 0, 1, 0, 2, "R4");
    send(3, 6, 1, 2, 0, 3, "R4");
    send(1, 1, 1, 1, 4, 0, "R4");
    // R5 each index register
    for (int s = 0; s < 4; s++) send(2, 1, 0, s, 0, s, "R5");
    wr_idle();
    // R6 offset legality
    send(0, 0, 0, 0, 12, 0, "R6");
    send(0, 0, 0, 0, 13, 0, "R6");
    send(1, 0, 0, 0, 8, 0, "R6");
    send(2, 0, 0, 0, 4, 0, "R6");
    send(3, 0, 1, 0, 0, 0, "R6");
    // R7 / R8 tile range and zeroed error output
    send(1, 2, 0, 0, 0, 7, "R7");
    send(0, 1, 1, 0, 0, 7, "R8");
    send(3, 7, 0, 3, 0, 7, "R7");
    // R9 top destination group
    send(0, 0, 1, 2, 4, 7, "R9");
    wr_idle();
    // R10 write in the same cycle as a read of that row, then read again
    send(0, 0, 0, 0, 0, 1, "R10", 1'b1, 7);
    send(0, 0, 0, 0, 0, 1, "R10");
    wr_idle();
    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R1", "all responses seen", 4096'(sbq.size()), 4096'(0));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule